// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Walking Squash

This block holds in-flight operations for up to four hardware threads. Every thread owns a small circular queue, and its entries are stored in program order. An entry is appended at dispatch with a thread number and a sequence number. A completion marks the entry ready, and a per-thread retire request removes the oldest entry of that thread once it is ready. Across all threads, a global oldest pointer and a global youngest pointer are derived from the sequence numbers found at the ends of the queues. Only threads enabled in an activity mask take part in these pointers.

A squash request names a thread and a sequence-number bound, and nothing is deleted. From the cycle after the request, a walker starts at the youngest entry of that thread and moves toward older entries. It handles at most `SQW` entries per cycle and flags each visited entry that is younger than the bound as squashed and ready. Those entries then leave through ordinary retirement. The whole buffer is shared up to a total capacity `CAP`, and each thread queue holds at most `TDEPTH` entries (`TDEPTH` must be a power of two).

Top module: `mt_reorder_buf`

## Requirements
- R1: An accepted dispatch writes the entry into the slot given by `disp_slot`. After reset, a thread's entries take slots 0, 1, 2, ... and wrap modulo `TDEPTH`. Each new entry starts neither ready nor squashed, and it raises the occupancy of its thread and of the whole buffer by one.
- R2: `disp_ready` is low in each of these cases: the total occupancy equals `CAP`, the target thread holds `TDEPTH` entries, the target thread is squashing, or a squash request for that same thread is present in the same cycle. A dispatch offered while `disp_ready` is low has no effect.
- R3: A completion (`cmpl_valid`, `cmpl_tid`, `cmpl_slot`) marks the addressed live entry ready from the next cycle on.
- R4: A retire request for a thread removes that thread's oldest entry only when the entry exists and is ready. In that case `retire_done` for the thread is high in the same cycle. In any other case the request is ignored.
- R5: `gh_valid/gh_tid/gh_seq` name the smallest oldest-entry sequence number among the active, non-empty threads. When there is no such thread, all three read 0.
- R6: `gt_valid/gt_tid/gt_seq` name the largest youngest-entry sequence number among the active, non-empty threads. When there is no such thread, all three read 0.
- R7: `commit_ok` is high exactly when some active thread has an oldest entry that is ready.
- R8: For a thread with no entries, `old_seq` reads 0 and both `old_rdy` and `old_sqd` read 0.
- R9: A squash request that arrives while the whole buffer is empty is ignored, and `sq_busy` is left unchanged.
- R10: An accepted squash raises `sq_busy` for its thread. In each following cycle the walker handles at most `SQW` entries, going from youngest toward oldest. It flags each entry whose sequence number is strictly above the bound as squashed and ready. The walk stops at an entry that is at or below the bound, or after the oldest entry has been handled, and `sq_busy` falls at the end of that cycle.
- R11: While a thread is squashing, and in the cycle of its squash request, the thread's retire requests are ignored. Squash stepping has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_mask | input | NTHR | Threads taking part in the global pointers and `commit_ok` |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | TW | Dispatch thread |
| disp_seq | input | SEQW | Dispatch sequence number |
| disp_ready | output | 1 | Dispatch would be accepted |
| disp_slot | output | IW | Slot the dispatch writes |
| cmpl_valid | input | 1 | Completion request |
| cmpl_tid | input | TW | Completion thread |
| cmpl_slot | input | IW | Completion slot |
| retire_req | input | NTHR | Per-thread retire request |
| retire_done | output | NTHR | Per-thread retire accepted |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TW | Squash thread |
| sq_bound | input | SEQW | Entries above this are squashed |
| sq_busy | output | NTHR | Per-thread squash in progress |
| old_seq | output | NTHR*SEQW | Per-thread oldest sequence number (0 if empty) |
| old_rdy | output | NTHR | Per-thread oldest entry ready |
| old_sqd | output | NTHR | Per-thread oldest entry squashed |
| commit_ok | output | 1 | Some active thread can retire |
| gh_valid | output | 1 | Global oldest valid |
| gh_tid | output | TW | Global oldest thread |
| gh_seq | output | SEQW | Global oldest sequence number |
| gt_valid | output | 1 | Global youngest valid |
| gt_tid | output | TW | Global youngest thread |
| gt_seq | output | SEQW | Global youngest sequence number |

## Verification
Some properties are checked on every cycle. Occupancy never exceeds `CAP`, and `disp_ready` is low at capacity. The global oldest and youngest pointers are compared with every active non-empty thread's oldest number. An empty thread shows the dummy value. Any squashed oldest entry is also ready. A squash on an empty buffer leaves `sq_busy` untouched, and a squashing thread's oldest entry stays frozen. Other behaviour only shows up in the scenarios, which compare against a bench model: the exact per-cycle walk progress at width `SQW`, where the walk stops relative to the bound, the slot numbering after wrap, and the rejection of retires of unready entries.

// File: rtl/mt_reorder_buf.sv
module mt_reorder_buf #(
  parameter int NTHR   = 4,
  parameter int TDEPTH = 8,
  parameter int CAP    = 12,
  parameter int SQW    = 2,
  parameter int SEQW   = 16,
  localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int IW    = (TDEPTH > 1) ? $clog2(TDEPTH) : 1,
  localparam int CW    = $clog2(TDEPTH + 1),
  localparam int TCW   = $clog2(CAP + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR-1:0]      act_mask,
  input  logic                 disp_valid,
  input  logic [TW-1:0]        disp_tid,
  input  logic [SEQW-1:0]      disp_seq,
  output logic                 disp_ready,
  output logic [IW-1:0]        disp_slot,
  input  logic                 cmpl_valid,
  input  logic [TW-1:0]        cmpl_tid,
  input  logic [IW-1:0]        cmpl_slot,
  input  logic [NTHR-1:0]      retire_req,
  output logic [NTHR-1:0]      retire_done,
  input  logic                 sq_valid,
  input  logic [TW-1:0]        sq_tid,
  input  logic [SEQW-1:0]      sq_bound,
  output logic [NTHR-1:0]      sq_busy,
  output logic [NTHR*SEQW-1:0] old_seq,
  output logic [NTHR-1:0]      old_rdy,
  output logic [NTHR-1:0]      old_sqd,
  output logic                 commit_ok,
  output logic                 gh_valid,
  output logic [TW-1:0]        gh_tid,
  output logic [SEQW-1:0]      gh_seq,
  output logic                 gt_valid,
  output logic [TW-1:0]        gt_tid,
  output logic [SEQW-1:0]      gt_seq
);

  logic [TCW-1:0]                tot;
  logic [NTHR-1:0]               ne_a, full_a, ret_acc;
  logic [NTHR-1:0][IW-1:0]       tl_a;
  logic [NTHR-1:0][SEQW-1:0]     os_a, ys_a;

  wire disp_acc = disp_valid && disp_ready;
  wire sq_acc   = sq_valid && (tot != '0);

  assign disp_ready = (tot < TCW'(CAP)) && !full_a[disp_tid] && !sq_busy[disp_tid]
                      && !(sq_valid && sq_tid == disp_tid);
  assign disp_slot  = tl_a[disp_tid];
  assign retire_done = ret_acc;
  assign old_seq    = os_a;
  assign commit_ok  = |(old_rdy & act_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tot <= '0;
    else        tot <= tot + TCW'(disp_acc) - TCW'($countones(ret_acc));

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic [SEQW-1:0]   seq_q [TDEPTH];
    logic [TDEPTH-1:0] rdy_q, sqd_q, rdy_n, sqd_n, mk, dbit, cbit, w_mark;
    logic [IW-1:0]     hd, tl, wk, w_idx;
    logic [CW-1:0]     cnt, wl, w_left;
    logic [SEQW-1:0]   bnd;
    logic              busy, w_fin;

    wire me_disp = disp_acc && (disp_tid == TW'(g));
    wire me_cmpl = cmpl_valid && (cmpl_tid == TW'(g));
    wire me_sq   = sq_acc && (sq_tid == TW'(g));

    always_comb begin
      w_idx  = wk;
      w_left = wl;
      w_fin  = 1'b0;
      w_mark = '0;
      for (int k = 0; k < SQW; k++) begin
        if (!w_fin) begin
          if (w_left == '0 || seq_q[w_idx] <= bnd) w_fin = 1'b1;
          else begin
            w_mark[w_idx] = 1'b1;
            w_idx  = w_idx - 1'b1;
            w_left = w_left - 1'b1;
          end
        end
      end
      if (!w_fin && (w_left == '0 || seq_q[w_idx] <= bnd)) w_fin = 1'b1;
    end

    assign mk    = busy ? w_mark : '0;
    assign dbit  = TDEPTH'(me_disp) << tl;
    assign cbit  = TDEPTH'(me_cmpl) << cmpl_slot;
    assign rdy_n = (rdy_q | mk | cbit) & ~dbit;
    assign sqd_n = (sqd_q | mk) & ~dbit;

    assign ret_acc[g] = retire_req[g] && (cnt != '0) && rdy_q[hd] && !busy && !me_sq;
    assign ne_a[g]    = cnt != '0;
    assign full_a[g]  = cnt == CW'(TDEPTH);
    assign tl_a[g]    = tl;
    assign sq_busy[g] = busy;
    assign os_a[g]    = ne_a[g] ? seq_q[hd] : '0;
    assign ys_a[g]    = seq_q[tl - 1'b1];
    assign old_rdy[g] = ne_a[g] && rdy_q[hd];
    assign old_sqd[g] = ne_a[g] && sqd_q[hd];

    always_ff @(posedge clk)
      if (me_disp) seq_q[tl] <= disp_seq;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hd <= '0; tl <= '0; cnt <= '0; rdy_q <= '0; sqd_q <= '0;
        busy <= 1'b0; bnd <= '0; wk <= '0; wl <= '0;
      end else begin
        rdy_q <= rdy_n;
        sqd_q <= sqd_n;
        if (me_disp)    tl <= tl + 1'b1;
        if (ret_acc[g]) hd <= hd + 1'b1;
        cnt <= cnt + CW'(me_disp) - CW'(ret_acc[g]);
        if (me_sq) begin
          busy <= 1'b1;
          bnd  <= sq_bound;
          wk   <= tl - 1'b1;
          wl   <= cnt;
        end else if (busy) begin
          wk <= w_idx;
          wl <= w_left;
          if (w_fin) busy <= 1'b0;
        end
      end
  end

  always_comb begin
    gh_valid = 1'b0; gh_tid = '0; gh_seq = '0;
    gt_valid = 1'b0; gt_tid = '0; gt_seq = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (act_mask[t] && ne_a[t] && (!gh_valid || os_a[t] < gh_seq)) begin
        gh_valid = 1'b1; gh_tid = TW'(t); gh_seq = os_a[t];
      end
      if (act_mask[t] && ne_a[t] && (!gt_valid || ys_a[t] > gt_seq)) begin
        gt_valid = 1'b1; gt_tid = TW'(t); gt_seq = ys_a[t];
      end
    end
  end

endmodule

// File: rtl/mt_reorder_buf_chk.sv
module mt_reorder_buf_chk #(
  parameter int NTHR = 4,
  parameter int SEQW = 16,
  parameter int CAP  = 12,
  parameter int TCW  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NTHR-1:0]      act_mask,
  input logic [TCW-1:0]       tot,
  input logic [NTHR-1:0]      ne_a,
  input logic                 sq_valid,
  input logic [NTHR-1:0]      sq_busy,
  input logic [NTHR*SEQW-1:0] old_seq,
  input logic [NTHR-1:0]      old_rdy,
  input logic [NTHR-1:0]      old_sqd,
  input logic                 gh_valid,
  input logic [SEQW-1:0]      gh_seq,
  input logic                 gt_valid,
  input logic [SEQW-1:0]      gt_seq,
  input logic                 disp_ready
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tot <= TCW'(CAP)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (tot == TCW'(CAP)) |-> !disp_ready); // R2
  AST_EMPTY_NO_PTR: assert property (@(posedge clk) disable iff (!rst_n) (tot == '0) |-> (!gh_valid && !gt_valid)); // R5
  AST_SQ_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (sq_valid && tot == '0) |=> (sq_busy == $past(sq_busy))); // R9

  for (genvar t = 0; t < NTHR; t++) begin : g_a
    AST_HEAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (gh_valid && act_mask[t] && ne_a[t]) |-> (gh_seq <= old_seq[t*SEQW +: SEQW])); // R5
    AST_TAIL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (gt_valid && act_mask[t] && ne_a[t]) |-> (gt_seq >= old_seq[t*SEQW +: SEQW])); // R6
    AST_DUMMY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !ne_a[t] |-> (old_seq[t*SEQW +: SEQW] == '0 && !old_rdy[t] && !old_sqd[t])); // R8
    AST_SQD_READY: assert property (@(posedge clk) disable iff (!rst_n) old_sqd[t] |-> old_rdy[t]); // R10
    AST_SQ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      sq_busy[t] |=> (old_seq[t*SEQW +: SEQW] == $past(old_seq[t*SEQW +: SEQW]))); // R11
  end

endmodule

bind mt_reorder_buf mt_reorder_buf_chk #(.NTHR(NTHR), .SEQW(SEQW), .CAP(CAP), .TCW(TCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_mask(act_mask), .tot(tot), .ne_a(ne_a),
  .sq_valid(sq_valid), .sq_busy(sq_busy), .old_seq(old_seq), .old_rdy(old_rdy),
  .old_sqd(old_sqd), .gh_valid(gh_valid), .gh_seq(gh_seq), .gt_valid(gt_valid),
  .gt_seq(gt_seq), .disp_ready(disp_ready)
);

// File: tb/sim_mt_reorder_buf.sv
`timescale 1ns/1ps
module sim_mt_reorder_buf;
  localparam int NT = 4, TD = 8, CAP = 12, SQW = 2;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [3:0]  act = 4'hF;
  logic        d_v = 0;  logic [1:0] d_tid = 0; logic [15:0] d_seq = 0;
  logic        c_v = 0;  logic [1:0] c_tid = 0; logic [2:0]  c_slot = 0;
  logic [3:0]  r_req = 0;
  logic        s_v = 0;  logic [1:0] s_tid = 0; logic [15:0] s_seq = 0;
  logic        disp_ready, commit_ok, gh_valid, gt_valid;
  logic [2:0]  disp_slot;
  logic [3:0]  retire_done, sq_busy, old_rdy, old_sqd;
  logic [63:0] old_seq;
  logic [1:0]  gh_tid, gt_tid;
  logic [15:0] gh_seq, gt_seq;

  mt_reorder_buf u0 (
    .clk(clk), .rst_n(rst_n), .act_mask(act),
    .disp_valid(d_v), .disp_tid(d_tid), .disp_seq(d_seq),
    .disp_ready(disp_ready), .disp_slot(disp_slot),
    .cmpl_valid(c_v), .cmpl_tid(c_tid), .cmpl_slot(c_slot),
    .retire_req(r_req), .retire_done(retire_done),
    .sq_valid(s_v), .sq_tid(s_tid), .sq_bound(s_seq), .sq_busy(sq_busy),
    .old_seq(old_seq), .old_rdy(old_rdy), .old_sqd(old_sqd), .commit_ok(commit_ok),
    .gh_valid(gh_valid), .gh_tid(gh_tid), .gh_seq(gh_seq),
    .gt_valid(gt_valid), .gt_tid(gt_tid), .gt_seq(gt_seq));

  int nchk = 0, nfail = 0;
  int m_seq [NT][TD];
  bit m_rdy [NT][TD];
  bit m_sqd [NT][TD];
  int m_hd[NT], m_tl[NT], m_cnt[NT], m_wk[NT], m_wl[NT], m_bnd[NT];
  bit m_busy[NT];
  int m_tot = 0;
  int nxt = 1;

  task automatic chk(bit ok, string req, string what, longint a, longint e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  function automatic bit exp_ready();
    return m_tot < CAP && m_cnt[d_tid] < TD && !m_busy[d_tid] && !(s_v && s_tid == d_tid);
  endfunction

  function automatic bit exp_ret(int t);
    bit sacc = s_v && m_tot != 0;
    return r_req[t] && m_cnt[t] > 0 && m_rdy[t][m_hd[t]] && !m_busy[t] && !(sacc && s_tid == t);
  endfunction

  function automatic int o_seq(int t);
    return m_cnt[t] > 0 ? m_seq[t][m_hd[t]] : 0;
  endfunction

  function automatic int y_seq(int t);
    return m_seq[t][(m_tl[t] + TD - 1) % TD];
  endfunction

  task automatic check_all();
    int hv = 0, ht = 0, hs = 0, tv = 0, tt = 0, ts = 0;
    bit cok = 0;
    chk(disp_ready == exp_ready(), "R2", "disp_ready", disp_ready, exp_ready());
    chk(disp_slot == m_tl[d_tid] % TD, "R1", "disp_slot", disp_slot, m_tl[d_tid] % TD);
    for (int t = 0; t < NT; t++) begin
      bit er = m_cnt[t] > 0 && m_rdy[t][m_hd[t]];
      bit es = m_cnt[t] > 0 && m_sqd[t][m_hd[t]];
      chk(old_seq[t*16 +: 16] == o_seq(t), "R8", "old_seq", old_seq[t*16 +: 16], o_seq(t));
      chk(old_rdy[t] == er, "R3", "old_rdy", old_rdy[t], er);
      chk(old_sqd[t] == es, "R10", "old_sqd", old_sqd[t], es);
      chk(sq_busy[t] == m_busy[t], "R10", "sq_busy", sq_busy[t], m_busy[t]);
      chk(retire_done[t] == exp_ret(t), "R4", "retire_done", retire_done[t], exp_ret(t));
      if (act[t] && m_cnt[t] > 0) begin
        if (er) cok = 1;
        if (!hv || o_seq(t) < hs) begin hv = 1; ht = t; hs = o_seq(t); end
        if (!tv || y_seq(t) > ts) begin tv = 1; tt = t; ts = y_seq(t); end
      end
    end
    chk(commit_ok == cok, "R7", "commit_ok", commit_ok, cok);
    chk(gh_valid == hv && gh_tid == ht && gh_seq == hs, "R5", "global head",
        {gh_valid, gh_tid, gh_seq}, {hv[0], ht[1:0], hs[15:0]});
    chk(gt_valid == tv && gt_tid == tt && gt_seq == ts, "R6", "global tail",
        {gt_valid, gt_tid, gt_seq}, {tv[0], tt[1:0], ts[15:0]});
  endtask

  task automatic update();
    bit dacc = d_v && exp_ready();
    bit sacc = s_v && m_tot != 0;
    bit racc [NT];
    for (int t = 0; t < NT; t++) racc[t] = exp_ret(t);
    for (int t = 0; t < NT; t++) if (m_busy[t]) begin
      int idx = m_wk[t], left = m_wl[t];
      bit fin = 0;
      for (int k = 0; k < SQW; k++) if (!fin) begin
        if (left == 0 || m_seq[t][idx] <= m_bnd[t]) fin = 1;
        else begin
          m_rdy[t][idx] = 1; m_sqd[t][idx] = 1;
          idx = (idx + TD - 1) % TD; left--;
        end
      end
      if (!fin && (left == 0 || m_seq[t][idx] <= m_bnd[t])) fin = 1;
      m_wk[t] = idx; m_wl[t] = left;
      if (fin) m_busy[t] = 0;
    end
    if (c_v) m_rdy[c_tid][c_slot] = 1;
    if (dacc) begin
      m_seq[d_tid][m_tl[d_tid]] = d_seq;
      m_rdy[d_tid][m_tl[d_tid]] = 0; m_sqd[d_tid][m_tl[d_tid]] = 0;
      m_tl[d_tid] = (m_tl[d_tid] + 1) % TD; m_cnt[d_tid]++; m_tot++;
    end
    for (int t = 0; t < NT; t++) if (racc[t]) begin
      m_hd[t] = (m_hd[t] + 1) % TD; m_cnt[t]--; m_tot--;
    end
    if (sacc) begin
      m_busy[s_tid] = 1; m_bnd[s_tid] = s_seq;
      m_wk[s_tid] = (m_tl[s_tid] + TD - 1) % TD; m_wl[s_tid] = m_cnt[s_tid];
    end
  endtask

  task automatic tick();
    #1;
    check_all();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    d_v = 0; c_v = 0; r_req = 0; s_v = 0;
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin
      m_hd[t] = 0; m_tl[t] = 0; m_cnt[t] = 0; m_busy[t] = 0; m_wk[t] = 0; m_wl[t] = 0; m_bnd[t] = 0;
      for (int i = 0; i < TD; i++) begin m_seq[t][i] = 0; m_rdy[t][i] = 0; m_sqd[t][i] = 0; end
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(gh_valid == 0 && gt_valid == 0, "R5", "reset pointers", {gh_valid, gt_valid}, 0);
    chk(old_seq == 0 && old_rdy == 0, "R8", "reset dummy", old_seq, 0);
    chk(disp_ready == 1 && commit_ok == 0, "R2", "reset ready", {disp_ready, commit_ok}, 2'b10);
    @(negedge clk);

    // R9: squash on empty buffer
    idle(); s_v = 1; s_tid = 2; s_seq = 5; tick(); idle();
    chk(sq_busy == 0, "R9", "squash on empty", sq_busy, 0);

    // R10: directed walk on thread 1, bound 20, width 2
    for (int i = 1; i <= 5; i++) begin d_v = 1; d_tid = 1; d_seq = 16'(10 * i); tick(); end
    idle();
    chk(disp_slot == 5 || d_tid != 1, "R1", "slot after five", disp_slot, 5);
    s_v = 1; s_tid = 1; s_seq = 20; r_req = 4'b0010; tick(); idle();
    chk(sq_busy[1] == 1, "R10", "walk started", sq_busy[1], 1);
    r_req = 4'b0010; tick(); idle();
    chk(sq_busy[1] == 1, "R10", "walk after one step", sq_busy[1], 1);
    chk(old_sqd[1] == 0 && old_seq[31:16] == 10, "R11", "oldest kept", old_seq[31:16], 10);
    tick();
    chk(sq_busy[1] == 0, "R10", "walk done at bound", sq_busy[1], 0);
    chk(old_seq[63:48] == 0 && old_rdy[3] == 0, "R8", "empty thread dummy", old_seq[63:48], 0);
    // R4: retire of unready oldest is ignored
    r_req = 4'b0010; tick(); idle();
    chk(old_seq[31:16] == 10, "R4", "unready not retired", old_seq[31:16], 10);
    nxt = 100;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      idle();
      if ($urandom % 50 == 0) act = 4'($urandom);
      else if ($urandom % 12 == 0) act = 4'hF;
      d_tid = 2'($urandom); d_seq = 16'(nxt);
      if ($urandom % 3 != 0) begin d_v = 1; nxt++; end
      c_tid = 2'($urandom);
      if (m_cnt[c_tid] > 0) begin
        c_v = 1; c_slot = 3'((m_hd[c_tid] + $urandom % m_cnt[c_tid]) % TD);
      end
      r_req = 4'($urandom);
      if ($urandom % 40 == 0) begin
        s_v = 1; s_tid = 2'($urandom);
        if (m_cnt[s_tid] > 0)
          s_seq = 16'(m_seq[s_tid][(m_hd[s_tid] + $urandom % m_cnt[s_tid]) % TD] - $urandom % 2);
        else s_seq = 16'($urandom % 50);
      end
      tick();
    end
    idle(); tick();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule